// File: doc/BRIEF.md
# Delayed-Sampling SPI Master

This block is an SPI master for slaves that launch each new MISO bit after a falling SCLK edge and also capture MOSI on that same falling edge. Most masters sample MISO on an SCLK edge. That is too early for such a slave when its output access time is long compared with the system clock. This master instead captures MISO a programmable number of system-clock cycles after each falling edge. The slave's access time is therefore met without moving the MOSI timing: MOSI still changes only on rising edges.

The master moves one 16-bit word at a time, most significant bit first. A host presents the transmit word, the SCLK half-period (`half_div`, in system-clock cycles) and the sample delay (`smp_dly`), then pulses `start`. `busy` covers the whole frame. A one-cycle `done` pulse marks the point from which `rx_word` holds the received word.

Internally a state machine steps through the states IDLE, LEAD, LOW, HIGH and TRAIL, with these transitions:
- IDLE→LEAD on an accepted start.
- LEAD→LOW after one half-period.
- LOW→HIGH after a half-period when bits remain.
- LOW→TRAIL after the half-period of the sixteenth bit.
- HIGH→LOW after a half-period.
- TRAIL→IDLE after a half-period.

A phase timer measures the half-periods. A separate delay sampler arms on every falling edge and fires after the delay.

Top module: `spi_dly_master`

## Requirements
- R1: After reset and whenever no transfer is in progress, `cs_n`=1, `sclk`=1, `busy`=0 and `done`=0.
- R2: A `start` seen while idle is accepted. `busy` is 1 from the next cycle for exactly 33·H cycles, where H = `half_div` as sampled with that `start`.
- R3: In a frame, `cs_n` falls when `busy` rises. `sclk` stays high for H cycles before the first falling edge. There are exactly 16 SCLK low phases and 15 high phases between them, each H cycles long. `cs_n` rises H cycles after the last rising edge.
- R4: MOSI carries `tx_word` most significant bit first. It changes only in the cycle where SCLK rises, and it is stable while SCLK is low, so a slave sampling on each falling edge receives `tx_word`.
- R5: With the cycle in which `sclk` first reads low counted as offset 0, MISO is captured in the cycle at offset D. The 16 captures, first one as bit 15, form `rx_word`. A slave whose data becomes valid before that capture point is read correctly; a slower one yields the previous bit.
- R6: D = min(`smp_dly`, 2H−1), so every capture completes before the next falling edge or the end of the frame.
- R7: `done` is a single-cycle pulse in the first cycle after `busy` falls. `rx_word` holds the received word from that cycle until the next accepted start.
- R8: `start` is ignored while `busy` is 1. The running frame and its results are unaffected, and no extra frame follows.
- R9: A `half_div` below 2 is treated as 2.
- R10: `tx_word`, `half_div` and `smp_dly` are sampled only with an accepted `start`. Changing them during a frame has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transfer (accepted only when idle) |
| tx_word | input | DATA_W | Word to transmit, MSB first |
| half_div | input | DIV_W | SCLK half-period in system-clock cycles (minimum 2) |
| smp_dly | input | DIV_W+1 | MISO capture delay after each falling edge, in cycles |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_word | output | DATA_W | Received word, valid from `done` |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |
| cs_n | output | 1 | Active-low slave select |

## Verification
The hardest situation to reach from the ports is a capture that races the slave: a transfer where the slave's data arrives just before the capture point, and another where it arrives just after. The bench models a slave that updates MISO a programmable number of nanoseconds after each SCLK fall. It runs the same word with that latency below and above the configured delay, and expects the exact word in the first case and the word shifted by one bit in the second. For the clamp, it requests a delay far beyond the SCLK period at the shortest half-period. The capture then lands on the last cycle before the next falling edge, and a slave latency longer than a whole SCLK period still yields a predictable one-bit shift.

// File: rtl/spi_dly_pkg.sv
package spi_dly_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_TRAIL
    } spi_state_e;

    localparam int MIN_HALF = 2;

endpackage

// File: rtl/spi_dly_phase_timer.sv
// Counts system-clock cycles inside one SCLK half-period.
module spi_dly_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half,
    output logic             ph_first,
    output logic             ph_end
);
    logic [DIV_W-1:0] cnt;

    assign ph_first = (cnt == '0);
    assign ph_end   = (cnt == half - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || ph_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    // R3: the phase counter never runs past the half-period
    assert_phase_in_range_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt < half));

endmodule

// File: rtl/spi_dly_sampler.sv
// Arms on each falling SCLK edge and captures MISO a set number of cycles later.
module spi_dly_sampler #(
    parameter int DATA_W = 16,
    parameter int DLY_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall,
    input  logic [DLY_W-1:0]  dly,
    input  logic              miso,
    output logic [DATA_W-1:0] rx
);
    logic [DLY_W-1:0] wait_cnt;
    logic             armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt <= '0;
            armed    <= 1'b0;
            rx       <= '0;
        end else if (fall) begin
            if (dly == '0) begin
                rx    <= {rx[DATA_W-2:0], miso};
                armed <= 1'b0;
            end else begin
                wait_cnt <= dly;
                armed    <= 1'b1;
            end
        end else if (armed) begin
            if (wait_cnt == DLY_W'(1)) begin
                rx    <= {rx[DATA_W-2:0], miso};
                armed <= 1'b0;
            end else begin
                wait_cnt <= wait_cnt - DLY_W'(1);
            end
        end
    end

    // R6: the clamped delay always retires a capture before the next fall
    assert_no_rearm_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> !armed);

endmodule

// File: rtl/spi_dly_master.sv
module spi_dly_master
    import spi_dly_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [DIV_W:0]    smp_dly,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int DLY_W = DIV_W + 1;
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    spi_state_e        state, nxt;
    logic [DATA_W-1:0] tx_sh;
    logic [DIV_W-1:0]  half_q, half_eff;
    logic [DLY_W-1:0]  dly_q, dly_eff, per_m1;
    logic [CNT_W-1:0]  bit_cnt;
    logic              done_q;
    logic              ph_first, ph_end, fall;

    // Clamp the configuration seen with start
    always_comb begin
        half_eff = (half_div < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : half_div;
        per_m1   = {half_eff, 1'b0} - DLY_W'(1);
        dly_eff  = (smp_dly > per_m1) ? per_m1 : smp_dly;
    end

    spi_dly_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (state != ST_IDLE),
        .half     (half_q),
        .ph_first (ph_first),
        .ph_end   (ph_end)
    );

    assign fall = (state == ST_LOW) && ph_first;

    spi_dly_sampler #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .fall  (fall),
        .dly   (dly_q),
        .miso  (miso),
        .rx    (rx_word)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transition logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start)  nxt = ST_LEAD;
            ST_LEAD:  if (ph_end) nxt = ST_LOW;
            ST_LOW:   if (ph_end) nxt = (bit_cnt == LAST_BIT) ? ST_TRAIL : ST_HIGH;
            ST_HIGH:  if (ph_end) nxt = ST_LOW;
            ST_TRAIL: if (ph_end) nxt = ST_IDLE;
            default:              nxt = ST_IDLE;
        endcase
    end

    // Frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            half_q  <= DIV_W'(MIN_HALF);
            dly_q   <= '0;
            bit_cnt <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (state == ST_TRAIL) && ph_end;
            if (state == ST_IDLE && start) begin
                tx_sh   <= tx_word;
                half_q  <= half_eff;
                dly_q   <= dly_eff;
                bit_cnt <= '0;
            end else if (state == ST_LOW && ph_end && bit_cnt != LAST_BIT) begin
                bit_cnt <= bit_cnt + CNT_W'(1);
                tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    // Outputs
    always_comb begin
        cs_n = (state == ST_IDLE);
        busy = (state != ST_IDLE);
        sclk = (state != ST_LOW);
        mosi = tx_sh[DATA_W-1];
        done = done_q;
    end

    // R7: done lasts exactly one cycle
    assert_done_single_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done arrives in the first idle cycle after a frame
    assert_done_after_frame_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R8: a frame only begins in response to start
    assert_busy_needs_start_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R4: MOSI does not move while SCLK is held low
    assert_mosi_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk && $past(!sclk)) |-> $stable(mosi));

endmodule

// File: tb/spi_dly_master_tb.sv
`timescale 1ns/1ps
module spi_dly_master_tb_top;

    localparam int DATA_W = 16;
    localparam int DIV_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [DATA_W-1:0] tx_word = '0;
    logic [DIV_W-1:0]  half_div = 8'd2;
    logic [DIV_W:0]    smp_dly = '0;
    logic              busy, done, sclk, mosi, cs_n;
    logic              miso = 1'b0;
    logic [DATA_W-1:0] rx_word;

    spi_dly_master #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
        .half_div(half_div), .smp_dly(smp_dly), .busy(busy), .done(done),
        .rx_word(rx_word), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #2 clk = ~clk;   // 250 MHz

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- slave model ----------------
    logic [DATA_W-1:0] slave_word = '0;
    logic [DATA_W-1:0] mosi_cap = '0;
    int slave_ns = 0;
    int bit_i = DATA_W - 1;
    int falls = 0;

    task automatic drive_later(input logic b, input int d);
        fork
            begin
                #(d);
                miso = b;
            end
        join_none
    endtask

    always @(negedge sclk) begin
        if (rst_n && !cs_n) begin
            mosi_cap = {mosi_cap[DATA_W-2:0], mosi};
            falls++;
            if (bit_i >= 0) drive_later(slave_word[bit_i], slave_ns);
            bit_i--;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] tx;
        int                cyc;
        int                half;
    } exp_t;

    exp_t exp_q[$];
    int busy_cnt = 0;
    int lead_cnt = 0;
    int done_seen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cnt++;
            if (!cs_n && sclk && falls == 0) lead_cnt++;
            if (done) begin
                done_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rx_word == e.rx, "R5", "rx_word", int'(rx_word), int'(e.rx));
                    check(mosi_cap == e.tx, "R4", "slave saw MOSI", int'(mosi_cap), int'(e.tx));
                    check(busy_cnt == e.cyc, "R2", "busy cycles", busy_cnt, e.cyc);
                    check(lead_cnt == e.half, "R3", "lead cycles", lead_cnt, e.half);
                    check(falls == DATA_W, "R3", "falling edges", falls, DATA_W);
                end
                busy_cnt = 0;
                lead_cnt = 0;
            end
        end
    end

    // ---------------- driver ----------------
    task automatic run_xfer(input logic [DATA_W-1:0] tx, input logic [DATA_W-1:0] sw,
                            input int hd, input int dly, input int sd,
                            input bit late, input bit poke);
        int h;
        exp_t e;
        logic [DATA_W-1:0] held;
        h = (hd < 2) ? 2 : hd;
        @(negedge clk);
        slave_word = sw;
        slave_ns   = sd;
        bit_i      = DATA_W - 1;
        falls      = 0;
        miso       = 1'b0;
        mosi_cap   = '0;
        tx_word    = tx;
        half_div   = DIV_W'(hd);
        smp_dly    = (DIV_W+1)'(dly);
        start      = 1'b1;
        e.tx   = tx;
        e.rx   = late ? {1'b0, sw[DATA_W-1:1]} : sw;
        e.cyc  = 33 * h;
        e.half = h;
        exp_q.push_back(e);
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R8/R10: new start and new settings while busy must be ignored
            repeat (20) @(negedge clk);
            tx_word  = ~tx;
            half_div = 8'd50;
            smp_dly  = '0;
            start    = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        held = rx_word;
        repeat (12) @(negedge clk);
        check(rx_word == held, "R7", "rx_word held after done", int'(rx_word), int'(held));
        check(cs_n && sclk && !busy && !done, "R1", "idle pins {cs_n,sclk,busy,done}",
              {cs_n, sclk, busy, done}, 4'b1100);
        repeat (20) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    int cyc_total = 0;
    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            check(1'b0, "WDOG", "watchdog expired", cyc_total, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n && sclk && !busy && !done, "R1", "reset pins {cs_n,sclk,busy,done}",
              {cs_n, sclk, busy, done}, 4'b1100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R5: 1 MHz SCLK, capture at 100 ns, slave valid at 60 ns -> exact
        run_xfer(16'hA5C3, 16'h3C5A, 125, 25, 60, 1'b0, 1'b0);
        // R5: capture at 40 ns, slave valid at 60 ns -> one-bit shift
        run_xfer(16'h1234, 16'hB3D1, 125, 10, 60, 1'b1, 1'b0);
        // R5: ~9.6 MHz SCLK, capture at 100 ns still inside the period
        run_xfer(16'hFFFF, 16'h8001, 13, 25, 60, 1'b0, 1'b0);
        // R6: request far beyond the period at H=4 -> clamped to 7 cycles
        run_xfer(16'h0F0F, 16'hC6A9, 4, 400, 20, 1'b0, 1'b0);
        // R6: slave slower than the clamped point -> one-bit shift
        run_xfer(16'h5555, 16'hC6A9, 4, 400, 40, 1'b1, 1'b0);
        // R9: half_div of 0 behaves as 2
        run_xfer(16'h8000, 16'h7FFE, 0, 3, 8, 1'b0, 1'b0);
        // R8 / R10: start and new settings during a frame are ignored
        run_xfer(16'hDEAD, 16'hBEEF, 2, 3, 8, 1'b0, 1'b1);

        repeat (200) @(negedge clk);
        check(done_seen == 7, "R8", "frames completed", done_seen, 7);
        check(exp_q.size() == 0, "R2", "frames still pending", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule